// File: doc/BRIEF.md
# Quadrature to Up/Down Pulse Converter

This block takes the two phase-shifted square waves of an incremental encoder and turns them into two separate trains of active-low pulses. One train is for forward motion and one is for reverse motion. A third active-low output pulses for every counted event, whichever the direction. The outputs can drive an up/down counter directly.

Both encoder inputs first pass through a synchronizer. Each then passes through an identical stability filter, so that contact bounce and dither at a stationary edge are ignored. A two-bit resolution select chooses which filtered edges produce a pulse: one, two or four per quadrature cycle.

Each pulse lasts a programmable number of system clocks. An event that arrives while a pulse is still being driven is dropped and raises a sticky overrun flag. An illegal transition, where both filtered channels change in the same clock, emits nothing and raises a sticky error flag.

Top module: `quad_clk_conv`

## Requirements
- R1: The resolution select `res_mode` is decoded as follows: 2'b00 is x1, 2'b01 is x2, and 2'b1x is x4. In x4, every filtered edge of A or B produces one pulse. In x2, only edges of A produce a pulse. In x1, only rising edges of A produce a pulse.
- R2: A filtered channel takes a new level only after its synchronized input has held that level for FILT_LEN (default 4) consecutive clocks. A shorter excursion produces no pulse.
- R3: `up_n` pulses low when A leads B. For inputs written as {A,B}, this is the sequence 00, 10, 11, 01, 00.
- R4: `dn_n` pulses low when A lags B. For inputs written as {A,B}, this is the sequence 00, 01, 11, 10, 00.
- R5: `cnt_n` is low whenever `up_n` or `dn_n` is low, and only then.
- R6: If both filtered channels change in the same clock, no pulse is produced. In that case `illegal_err` is set and stays set until reset.
- R7: The first low clock of a pulse is the clock after the filtered edge. A pulse stays low for `pulse_width` clocks, and a width value of 0 acts as 1.
- R8: A counted event that arrives while a pulse is active is dropped and sets `overrun_err`. The flag stays set until reset.
- R9: Reset is active-high and synchronous, and is held for at least two clocks. During reset all pulse outputs are high and both flags are cleared. The filters load the present input levels, so inputs that are steady through reset produce no pulse.
- R10: `up_n` and `dn_n` are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 1 | Encoder channel A, asynchronous |
| b_in | input | 1 | Encoder channel B, asynchronous |
| res_mode | input | 2 | Resolution select: 00 = x1, 01 = x2, 1x = x4 |
| pulse_width | input | PW_BITS | Pulse length in clocks; 0 acts as 1 |
| up_n | output | 1 | Forward pulse train, active low |
| dn_n | output | 1 | Reverse pulse train, active low |
| cnt_n | output | 1 | Pulse on every counted event, active low |
| illegal_err | output | 1 | Sticky flag for a simultaneous A/B change |
| overrun_err | output | 1 | Sticky flag for an event dropped during a pulse |

## Verification
Full forward and reverse quadrature cycles are applied in each of the three resolutions, including the 2'b11 alias of x4. The resulting pulse counts separate x1, x2 and x4 from one another and the forward direction from the reverse. Glitches of FILT_LEN-1 and of exactly FILT_LEN clocks separate rejection from acceptance by the filter. A simultaneous change of A and B, and a second edge placed inside a long pulse, exercise the two sticky flags. Single pulses at widths 5, 0 and 1 pin down the pulse length.

// File: rtl/qcc_pkg.sv
package qcc_pkg;

   typedef enum logic [1:0] {
      RES_X1 = 2'd0,
      RES_X2 = 2'd1,
      RES_X4 = 2'd2
   } res_e;

   function automatic res_e decode_res(input logic [1:0] sel);
      if (sel[1])
         return RES_X4;
      else if (sel[0])
         return RES_X2;
      else
         return RES_X1;
   endfunction

endpackage

// File: rtl/qcc_filter.sv
module qcc_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic raw,
   output logic filt
);

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (FILT_LEN >= 1) else $error("FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   s_last;
   logic                   filt_q;

   always_ff @(posedge clk) begin
      if (rst)
         sync_q <= {SYNC_STAGES{raw}};
      else
         sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
   end

   assign s_last = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_LEN == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (rst)
               filt_q <= raw;
            else
               filt_q <= s_last;
         end
      end else begin : g_count
         localparam int CW = $clog2(FILT_LEN);
         localparam logic [CW-1:0] RUN_LAST = CW'(FILT_LEN - 1);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               filt_q <= raw;
               run_q  <= '0;
            end else if (s_last == filt_q) begin
               run_q <= '0;
            end else if (run_q == RUN_LAST) begin
               filt_q <= s_last;
               run_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   assign filt = filt_q;

   // R2
   filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (filt_q != $past(filt_q)) |-> ($past(s_last) == filt_q));

endmodule

// File: rtl/qcc_decode.sv
module qcc_decode
   import qcc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       fa,
   input  logic       fb,
   input  logic [1:0] res_mode,
   output logic       evt_valid,
   output logic       evt_up,
   output logic       illegal_err
);

   logic pa_q, pb_q, ill_q;
   logic ea, eb, both, hit;
   res_e res;

   assign ea   = fa ^ pa_q;
   assign eb   = fb ^ pb_q;
   assign both = ea & eb;
   assign res  = decode_res(res_mode);

   always_comb begin
      unique case (res)
         RES_X4:  hit = ea | eb;
         RES_X2:  hit = ea;
         default: hit = ea & fa;
      endcase
   end

   assign evt_valid = hit & ~both;
   // An A edge moves A away from B when A leads; a B edge moves B onto A.
   assign evt_up    = ea ? (fa ^ fb) : ~(fa ^ fb);

   always_ff @(posedge clk) begin
      if (rst) begin
         pa_q  <= fa;
         pb_q  <= fb;
         ill_q <= 1'b0;
      end else begin
         pa_q <= fa;
         pb_q <= fb;
         if (both)
            ill_q <= 1'b1;
      end
   end

   assign illegal_err = ill_q;

   // R6
   illegal_set_chk: assert property (@(posedge clk) disable iff (rst)
      (ea && eb) |=> illegal_err);

   // R6
   illegal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      illegal_err |=> illegal_err);

endmodule

// File: rtl/qcc_pulse.sv
module qcc_pulse #(
   parameter int PW_BITS = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               evt_valid,
   input  logic               evt_up,
   input  logic [PW_BITS-1:0] width,
   output logic               up_n,
   output logic               dn_n,
   output logic               cnt_n,
   output logic               overrun_err
);

   initial begin
      assert (PW_BITS >= 1) else $error("PW_BITS must be at least 1");
   end

   logic [PW_BITS-1:0] left_q;
   logic [PW_BITS-1:0] eff_w;
   logic               dir_q;
   logic               ovr_q;
   logic               busy;

   assign busy  = (left_q != '0);
   assign eff_w = (width == '0) ? PW_BITS'(1) : width;

   always_ff @(posedge clk) begin
      if (rst) begin
         left_q <= '0;
         dir_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else if (evt_valid && !busy) begin
         left_q <= eff_w;
         dir_q  <= evt_up;
      end else begin
         if (busy)
            left_q <= left_q - 1'b1;
         if (evt_valid)
            ovr_q <= 1'b1;
      end
   end

   assign up_n        = ~(busy & dir_q);
   assign dn_n        = ~(busy & ~dir_q);
   assign cnt_n       = ~busy;
   assign overrun_err = ovr_q;

   // R7
   pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
      (evt_valid && cnt_n) |=> !cnt_n);

   // R8
   overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
      (evt_valid && !cnt_n) |=> overrun_err);

   // R8
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      overrun_err |=> overrun_err);

   // R5
   cnt_cover_chk: assert property (@(posedge clk) disable iff (rst)
      (!up_n || !dn_n) |-> !cnt_n);

   // R10
   up_dn_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(!up_n && !dn_n));

endmodule

// File: rtl/quad_clk_conv.sv
module quad_clk_conv #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4,
   parameter int PW_BITS     = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               a_in,
   input  logic               b_in,
   input  logic [1:0]         res_mode,
   input  logic [PW_BITS-1:0] pulse_width,
   output logic               up_n,
   output logic               dn_n,
   output logic               cnt_n,
   output logic               illegal_err,
   output logic               overrun_err
);

   localparam int NCH = 2;

   logic [NCH-1:0] raw;
   logic [NCH-1:0] filt;
   logic           evt_valid;
   logic           evt_up;

   assign raw = {b_in, a_in};

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
         qcc_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
         ) u_filt (
            .clk (clk),
            .rst (rst),
            .raw (raw[ch]),
            .filt(filt[ch])
         );
      end
   endgenerate

   qcc_decode u_dec (
      .clk        (clk),
      .rst        (rst),
      .fa         (filt[0]),
      .fb         (filt[1]),
      .res_mode   (res_mode),
      .evt_valid  (evt_valid),
      .evt_up     (evt_up),
      .illegal_err(illegal_err)
   );

   qcc_pulse #(
      .PW_BITS(PW_BITS)
   ) u_pulse (
      .clk        (clk),
      .rst        (rst),
      .evt_valid  (evt_valid),
      .evt_up     (evt_up),
      .width      (pulse_width),
      .up_n       (up_n),
      .dn_n       (dn_n),
      .cnt_n      (cnt_n),
      .overrun_err(overrun_err)
   );

   // R9
   reset_idle_chk: assert property (@(posedge clk)
      $past(rst) |-> (up_n && dn_n && cnt_n && !illegal_err && !overrun_err));

endmodule

// File: tb/quad_clk_conv_tb.sv
module quad_clk_conv_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 20;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       a_in = 1'b0;
   logic       b_in = 1'b0;
   logic [1:0] res_mode = 2'b10;
   logic [7:0] pulse_width = 8'd3;
   logic       up_n, dn_n, cnt_n, illegal_err, overrun_err;

   int tests = 0;
   int fails = 0;
   int up_falls = 0;
   int dn_falls = 0;
   int cnt_falls = 0;
   int both_low = 0;
   int run = 0;
   int last_w = 0;
   logic prev_up = 1'b1;
   logic prev_dn = 1'b1;
   logic prev_cnt = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_clk_conv dut_i (
      .clk        (clk),
      .rst        (rst),
      .a_in       (a_in),
      .b_in       (b_in),
      .res_mode   (res_mode),
      .pulse_width(pulse_width),
      .up_n       (up_n),
      .dn_n       (dn_n),
      .cnt_n      (cnt_n),
      .illegal_err(illegal_err),
      .overrun_err(overrun_err)
   );

   always @(negedge clk) begin
      if (prev_up && !up_n) up_falls++;
      if (prev_dn && !dn_n) dn_falls++;
      if (prev_cnt && !cnt_n) cnt_falls++;
      if (!up_n && !dn_n) both_low++;
      if (!cnt_n) run++;
      else if (run != 0) begin
         last_w = run;
         run = 0;
      end
      prev_up  = up_n;
      prev_dn  = dn_n;
      prev_cnt = cnt_n;
   end

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic a, input logic b);
      @(negedge clk);
      rst  = 1'b1;
      a_in = a;
      b_in = b;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic step(input logic a, input logic b);
      @(negedge clk);
      a_in = a;
      b_in = b;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic fwd_cycle();
      step(1, 0); step(1, 1); step(0, 1); step(0, 0);
   endtask

   task automatic rev_cycle();
      step(0, 1); step(1, 1); step(1, 0); step(0, 0);
   endtask

   task automatic t_reset();
      int u0, d0;
      @(negedge clk);
      rst = 1'b1;
      a_in = 1'b1;
      b_in = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 outputs idle in reset", {up_n, dn_n, cnt_n}, 3'b111);
      check("R9 flags clear in reset", {illegal_err, overrun_err}, 0);
      u0 = up_falls; d0 = dn_falls;
      rst = 1'b0;
      repeat (HOLD) @(negedge clk);
      check("R9 steady inputs give no pulse", (up_falls - u0) + (dn_falls - d0), 0);
   endtask

   task automatic t_x4();
      int u0, d0, c0;
      res_mode = 2'b10; pulse_width = 8'd3;
      do_reset(0, 0);
      u0 = up_falls; d0 = dn_falls; c0 = cnt_falls;
      fwd_cycle(); fwd_cycle();
      check("R3 x4 forward up pulses", up_falls - u0, 8);
      check("R3 x4 forward no down", dn_falls - d0, 0);
      check("R5 count pulses forward", cnt_falls - c0, 8);
      u0 = up_falls; d0 = dn_falls; c0 = cnt_falls;
      rev_cycle(); rev_cycle();
      check("R4 x4 reverse down pulses", dn_falls - d0, 8);
      check("R4 x4 reverse no up", up_falls - u0, 0);
      check("R5 count pulses reverse", cnt_falls - c0, 8);
      res_mode = 2'b11;
      u0 = up_falls;
      fwd_cycle();
      check("R1 mode 11 acts as x4", up_falls - u0, 4);
   endtask

   task automatic t_x2();
      int u0, d0;
      res_mode = 2'b01;
      do_reset(0, 0);
      u0 = up_falls; d0 = dn_falls;
      fwd_cycle();
      check("R1 x2 forward up pulses", up_falls - u0, 2);
      rev_cycle();
      check("R1 x2 reverse down pulses", dn_falls - d0, 2);
   endtask

   task automatic t_x1();
      int u0, d0;
      res_mode = 2'b00;
      do_reset(0, 0);
      u0 = up_falls; d0 = dn_falls;
      fwd_cycle(); fwd_cycle();
      check("R1 x1 forward up pulses", up_falls - u0, 2);
      rev_cycle(); rev_cycle();
      check("R1 x1 reverse down pulses", dn_falls - d0, 2);
   endtask

   task automatic t_width();
      res_mode = 2'b10;
      pulse_width = 8'd5;
      do_reset(0, 0);
      step(1, 0);
      check("R7 width 5", last_w, 5);
      pulse_width = 8'd0;
      step(1, 1);
      check("R7 width 0 acts as 1", last_w, 1);
      pulse_width = 8'd1;
      step(0, 1);
      check("R7 width 1", last_w, 1);
   endtask

   task automatic t_dither();
      int u0, d0;
      res_mode = 2'b10; pulse_width = 8'd3;
      do_reset(0, 0);
      u0 = up_falls; d0 = dn_falls;
      @(negedge clk); a_in = 1'b1;
      repeat (3) @(negedge clk); a_in = 1'b0;
      repeat (HOLD) @(negedge clk);
      check("R2 short glitch rejected", (up_falls - u0) + (dn_falls - d0), 0);
      @(negedge clk); a_in = 1'b1;
      repeat (4) @(negedge clk); a_in = 1'b0;
      repeat (HOLD) @(negedge clk);
      check("R2 full-length level accepted up", up_falls - u0, 1);
      check("R2 full-length return accepted down", dn_falls - d0, 1);
   endtask

   task automatic t_illegal();
      int c0, u0;
      res_mode = 2'b10; pulse_width = 8'd3;
      do_reset(0, 0);
      c0 = cnt_falls;
      step(1, 1);
      check("R6 simultaneous change no pulse", cnt_falls - c0, 0);
      check("R6 illegal flag set", illegal_err, 1);
      u0 = up_falls;
      step(0, 1);
      check("R6 illegal flag sticky", illegal_err, 1);
      check("R3 counting resumes after illegal", up_falls - u0, 1);
      do_reset(0, 0);
      check("R9 reset clears illegal", illegal_err, 0);
   endtask

   task automatic t_overrun();
      int c0;
      res_mode = 2'b10; pulse_width = 8'd200;
      do_reset(0, 0);
      c0 = cnt_falls;
      @(negedge clk); a_in = 1'b1;
      repeat (15) @(negedge clk); b_in = 1'b1;
      repeat (220) @(negedge clk);
      check("R8 event during pulse dropped", cnt_falls - c0, 1);
      check("R8 dropped pulse length unchanged", last_w, 200);
      check("R8 overrun flag set", overrun_err, 1);
      check("R6 no illegal on overrun", illegal_err, 0);
      pulse_width = 8'd3;
      step(0, 1);
      check("R8 overrun flag sticky", overrun_err, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_x4();
      t_x2();
      t_x1();
      t_width();
      t_dither();
      t_illegal();
      t_overrun();
      check("R10 up and down never low together", both_low, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule